// File: doc/BRIEF.md
# Interrupt Message Dispatcher with Rotating Target Choice

The dispatcher watches a bank of interrupt request lines. Each line has a redirection entry, supplied as a flat configuration bus. When a line rises, the dispatcher queues it. It serves queued lines one at a time. For each line it takes a snapshot of the entry and works out which processor contexts the message goes to. It then presents the message on a valid/ready output. The message carries a target bitmap (one bit per context), the vector, the delivery mode, the destination mode, the level bit and the trigger bit.

Targets are resolved in one of two ways. A physical destination compares each context's physical ID with the destination byte, and the byte 0xFF selects every context. A logical destination ANDs each context's logical ID with the destination byte. For lowest-priority delivery, the dispatcher keeps a rotation counter. It sends to a single candidate, chosen from the counter taken modulo the number of candidates. For external-controller delivery, the vector is fetched through a request/acknowledge handshake. Two single-cycle pulses report problems: one for an illegal mode combination and one for an empty target set.

Top module: `irq_msg_dispatcher`

## Requirements
- R1: A message is produced only when a line goes from its stored low state to high. A line held high produces exactly one message. Lowering the line produces nothing but allows the next rise to produce a new message.
- R2: Entry layout per line, at bits [23*i +: 23], from MSB to LSB: mask[22], destination[21:14], vector[13:6], delivery mode[5:3], destination mode[2], polarity[1], trigger[0]. A rise on a line whose mask bit is 1 produces no message, and it is not remembered: clearing the mask later does not release it.
- R3: When several unmasked lines rise in the same cycle, the messages come out in ascending line order, and none is lost.
- R4: For any delivery mode other than external (code 3'b111), the message vector equals the entry vector. The message delivery mode, destination mode (0 physical, 1 logical), level (= polarity) and trigger equal the entry's fields.
- R5: With delivery mode 3'b111, `ext_req` rises and stays high until `ext_ack` is seen. The message vector equals `ext_vector` sampled with the acknowledge.
- R6: Physical mode with destination 0xFF targets every context.
- R7: Physical mode with any other destination targets exactly the contexts whose physical ID equals the destination.
- R8: Logical mode targets exactly the contexts whose logical ID ANDed with the destination is nonzero.
- R9: Lowest-priority mode (code 3'b001) in logical mode targets one context. Number the candidates in ascending context order, starting at 0. The chosen candidate is the one at position (counter mod candidate count). The counter is 0 after reset and increments by one after each such choice.
- R10: Lowest-priority mode in physical mode raises `err_illegal` for one cycle, sends no message and leaves the rotation counter unchanged.
- R11: An empty candidate set raises `err_notarget` for one cycle and sends no message.
- R12: After reset, `msg_valid`, `ext_req` and both error pulses are low. While `msg_valid` is high and `msg_ready` is low, the message stays valid and unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_lines | input | NUM_LINES | Interrupt request lines |
| redir_cfg | input | NUM_LINES*23 | Redirection entries, one 23-bit field per line |
| ctx_phys_id | input | NUM_CTX*8 | Physical ID of each context |
| ctx_logic_id | input | NUM_CTX*8 | Logical ID of each context |
| ext_req | output | 1 | Vector request to the external controller |
| ext_ack | input | 1 | External controller acknowledge |
| ext_vector | input | 8 | Vector returned by the external controller |
| msg_valid | output | 1 | Message valid |
| msg_ready | input | 1 | Message accepted by the sink |
| msg_target | output | NUM_CTX | Target context bitmap |
| msg_vector | output | 8 | Message vector |
| msg_dmode | output | 3 | Delivery mode |
| msg_destm | output | 1 | Destination mode |
| msg_level | output | 1 | Level bit |
| msg_trigger | output | 1 | Trigger bit |
| err_illegal | output | 1 | Pulse: lowest priority with physical destination |
| err_notarget | output | 1 | Pulse: no matching context |

## Verification
The contexts are given overlapping IDs on purpose: two contexts share a physical ID and the logical IDs overlap. This lets a single physical destination match more than one context, and lets logical masks hit different subsets. A held line, a lowered-then-raised line and a masked-then-unmasked line separate real edge detection from level sensitivity and from queuing of masked edges. The bench runs a long run of lowest-priority requests over a four-candidate set and then over a two-candidate set. It predicts the rotation arithmetically, which exposes an off-by-one in the modulo or in the counter step. Three lines raised together while the sink stalls check the service order and that the stalled message does not change.

// File: rtl/irq_disp_pkg.sv
package irq_disp_pkg;

    localparam int VEC_W  = 8;
    localparam int ID_W   = 8;
    localparam int MODE_W = 3;

    typedef logic [MODE_W-1:0] dmode_t;

    localparam dmode_t DM_FIXED    = 3'b000;
    localparam dmode_t DM_LOWPRI   = 3'b001;
    localparam dmode_t DM_EXTERNAL = 3'b111;

    typedef struct packed {
        logic             mask;
        logic [ID_W-1:0]  dest;
        logic [VEC_W-1:0] vector;
        dmode_t           dmode;
        logic             destm;
        logic             polarity;
        logic             trigger;
    } redir_t;

    localparam int ENTRY_W = $bits(redir_t);

    typedef enum logic [1:0] {
        S_IDLE    = 2'd0,
        S_RESOLVE = 2'd1,
        S_FETCH   = 2'd2,
        S_SEND    = 2'd3
    } disp_state_t;

    function automatic logic is_broadcast(input logic [ID_W-1:0] d);
        return d == {ID_W{1'b1}};
    endfunction

endpackage

// File: rtl/irq_line_tracker.sv
module irq_line_tracker #(
    parameter int NUM_LINES = 8,
    localparam int IDX_W = $clog2(NUM_LINES)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NUM_LINES-1:0] line_in,
    input  logic [NUM_LINES-1:0] mask_vec,
    input  logic                 take,
    input  logic [IDX_W-1:0]     take_idx,
    output logic                 pend_any,
    output logic [IDX_W-1:0]     pick_idx
);

    logic [NUM_LINES-1:0] line_q;
    logic [NUM_LINES-1:0] pend_q;
    logic [NUM_LINES-1:0] pend_d;
    logic [NUM_LINES-1:0] rise;

    assign rise = line_in & ~line_q;

    always_comb begin
        pend_d = pend_q;
        if (take) pend_d[take_idx] = 1'b0;
        pend_d = pend_d | (rise & ~mask_vec);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            line_q <= '0;
            pend_q <= '0;
        end else begin
            line_q <= line_in;
            pend_q <= pend_d;
        end
    end

    assign pend_any = |pend_q;

    // lowest-numbered pending line wins
    always_comb begin
        pick_idx = '0;
        for (int i = NUM_LINES - 1; i >= 0; i--) begin
            if (pend_q[i]) pick_idx = IDX_W'(i);
        end
    end

    for (genvar g = 0; g < NUM_LINES; g++) begin : g_chk
        // R1: a line becomes pending only after a stored-low to high transition
        a_r1_edge_only: assert property (@(posedge clk) disable iff (rst)
            $rose(pend_q[g]) |-> $past(rise[g]));
        // R2: a masked edge never enters the queue
        a_r2_masked_dropped: assert property (@(posedge clk) disable iff (rst)
            (rise[g] && mask_vec[g] && !pend_q[g]) |=> !pend_q[g]);
    end

endmodule

// File: rtl/irq_target_resolver.sv
module irq_target_resolver
    import irq_disp_pkg::*;
#(
    parameter int NUM_CTX = 4,
    parameter int ROT_W   = 8
) (
    input  logic [ID_W-1:0]         dest,
    input  logic                    destm,
    input  dmode_t                  dmode,
    input  logic [NUM_CTX*ID_W-1:0] phys_ids,
    input  logic [NUM_CTX*ID_W-1:0] logic_ids,
    input  logic [ROT_W-1:0]        rot,
    output logic [NUM_CTX-1:0]      target,
    output logic                    empty,
    output logic                    illegal
);

    localparam int CNT_W = $clog2(NUM_CTX + 1);

    logic [NUM_CTX-1:0] phys_hit;
    logic [NUM_CTX-1:0] log_hit;
    logic [NUM_CTX-1:0] cand;
    logic [NUM_CTX-1:0] sel;
    logic [CNT_W-1:0]   count;
    logic [ROT_W-1:0]   pos;
    logic [ROT_W-1:0]   seen;
    logic               lowpri;

    for (genvar c = 0; c < NUM_CTX; c++) begin : g_ctx
        assign phys_hit[c] = is_broadcast(dest) ||
                             (phys_ids[c*ID_W +: ID_W] == dest);
        assign log_hit[c]  = |(logic_ids[c*ID_W +: ID_W] & dest);
    end

    assign cand   = destm ? log_hit : phys_hit;
    assign lowpri = (dmode == DM_LOWPRI);

    always_comb begin
        count = '0;
        for (int c = 0; c < NUM_CTX; c++) count = count + CNT_W'(cand[c]);
    end

    assign pos = (count == '0) ? '0 : rot % ROT_W'(count);

    always_comb begin
        seen = '0;
        sel  = '0;
        for (int c = 0; c < NUM_CTX; c++) begin
            if (cand[c]) begin
                if (seen == pos) sel[c] = 1'b1;
                seen = seen + 1'b1;
            end
        end
    end

    assign empty   = (cand == '0);
    assign illegal = lowpri && !destm;
    assign target  = lowpri ? sel : cand;

endmodule

// File: rtl/irq_msg_dispatcher.sv
module irq_msg_dispatcher
    import irq_disp_pkg::*;
#(
    parameter int NUM_LINES = 8,
    parameter int NUM_CTX   = 4,
    parameter int ROT_W     = 8
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic [NUM_LINES-1:0]         irq_lines,
    input  logic [NUM_LINES*ENTRY_W-1:0] redir_cfg,
    input  logic [NUM_CTX*ID_W-1:0]      ctx_phys_id,
    input  logic [NUM_CTX*ID_W-1:0]      ctx_logic_id,
    output logic                         ext_req,
    input  logic                         ext_ack,
    input  logic [VEC_W-1:0]             ext_vector,
    output logic                         msg_valid,
    input  logic                         msg_ready,
    output logic [NUM_CTX-1:0]           msg_target,
    output logic [VEC_W-1:0]             msg_vector,
    output logic [MODE_W-1:0]            msg_dmode,
    output logic                         msg_destm,
    output logic                         msg_level,
    output logic                         msg_trigger,
    output logic                         err_illegal,
    output logic                         err_notarget
);

    localparam int IDX_W = $clog2(NUM_LINES);

    redir_t               entries [NUM_LINES];
    logic [NUM_LINES-1:0] mask_vec;

    for (genvar i = 0; i < NUM_LINES; i++) begin : g_ent
        assign entries[i]  = redir_t'(redir_cfg[i*ENTRY_W +: ENTRY_W]);
        assign mask_vec[i] = entries[i].mask;
    end

    disp_state_t        state_q;
    redir_t             cur_q;
    logic [ROT_W-1:0]   rot_q;
    logic [NUM_CTX-1:0] tgt_q;
    logic [VEC_W-1:0]   vec_q;
    logic               err_ill_q;
    logic               err_nt_q;

    logic               pend_any;
    logic [IDX_W-1:0]   pick_idx;
    logic               take;
    logic [NUM_CTX-1:0] res_target;
    logic               res_empty;
    logic               res_illegal;

    assign take = (state_q == S_IDLE) && pend_any;

    irq_line_tracker #(.NUM_LINES(NUM_LINES)) u_track (
        .clk      (clk),
        .rst      (rst),
        .line_in  (irq_lines),
        .mask_vec (mask_vec),
        .take     (take),
        .take_idx (pick_idx),
        .pend_any (pend_any),
        .pick_idx (pick_idx)
    );

    irq_target_resolver #(.NUM_CTX(NUM_CTX), .ROT_W(ROT_W)) u_res (
        .dest      (cur_q.dest),
        .destm     (cur_q.destm),
        .dmode     (cur_q.dmode),
        .phys_ids  (ctx_phys_id),
        .logic_ids (ctx_logic_id),
        .rot       (rot_q),
        .target    (res_target),
        .empty     (res_empty),
        .illegal   (res_illegal)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= S_IDLE;
            cur_q     <= '0;
            rot_q     <= '0;
            tgt_q     <= '0;
            vec_q     <= '0;
            err_ill_q <= 1'b0;
            err_nt_q  <= 1'b0;
        end else begin
            err_ill_q <= 1'b0;
            err_nt_q  <= 1'b0;
            unique case (state_q)
                S_IDLE: begin
                    if (pend_any) begin
                        cur_q   <= entries[pick_idx];
                        state_q <= S_RESOLVE;
                    end
                end
                S_RESOLVE: begin
                    if (res_illegal) begin
                        err_ill_q <= 1'b1;
                        state_q   <= S_IDLE;
                    end else if (res_empty) begin
                        err_nt_q <= 1'b1;
                        state_q  <= S_IDLE;
                    end else begin
                        tgt_q <= res_target;
                        vec_q <= cur_q.vector;
                        if (cur_q.dmode == DM_LOWPRI) rot_q <= rot_q + 1'b1;
                        state_q <= (cur_q.dmode == DM_EXTERNAL) ? S_FETCH : S_SEND;
                    end
                end
                S_FETCH: begin
                    if (ext_ack) begin
                        vec_q   <= ext_vector;
                        state_q <= S_SEND;
                    end
                end
                S_SEND: begin
                    if (msg_ready) state_q <= S_IDLE;
                end
                default: state_q <= S_IDLE;
            endcase
        end
    end

    assign ext_req      = (state_q == S_FETCH);
    assign msg_valid    = (state_q == S_SEND);
    assign msg_target   = tgt_q;
    assign msg_vector   = vec_q;
    assign msg_dmode    = cur_q.dmode;
    assign msg_destm    = cur_q.destm;
    assign msg_level    = cur_q.polarity;
    assign msg_trigger  = cur_q.trigger;
    assign err_illegal  = err_ill_q;
    assign err_notarget = err_nt_q;

    // R12: a stalled message holds still
    a_r12_hold: assert property (@(posedge clk) disable iff (rst)
        (msg_valid && !msg_ready) |=> (msg_valid && $stable(msg_target) &&
                                       $stable(msg_vector) && $stable(msg_dmode)));
    // R11: no message leaves with an empty target bitmap
    a_r11_nonempty: assert property (@(posedge clk) disable iff (rst)
        msg_valid |-> (msg_target != '0));
    // R9: lowest-priority messages reach exactly one context
    a_r9_single: assert property (@(posedge clk) disable iff (rst)
        (msg_valid && msg_dmode == DM_LOWPRI) |-> ($countones(msg_target) == 1));
    // R9: the rotation counter moves only by one, and only after a lowest-priority choice
    a_r9_rot_step: assert property (@(posedge clk) disable iff (rst)
        (rot_q != $past(rot_q)) |-> (rot_q == $past(rot_q) + 1'b1 &&
                                     $past(cur_q.dmode) == DM_LOWPRI));
    // R10: an illegal combination sends nothing
    a_r10_no_send: assert property (@(posedge clk) disable iff (rst)
        err_illegal |-> (!msg_valid && !ext_req));
    // R5: the vector request is held until acknowledged
    a_r5_req_hold: assert property (@(posedge clk) disable iff (rst)
        (ext_req && !ext_ack) |=> ext_req);

endmodule

// File: tb/test_irq_msg_dispatcher.sv
module test_irq_msg_dispatcher;

    localparam int NL = 8;
    localparam int NC = 4;
    localparam int EW = 23;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [NL-1:0]     irq_lines = '0;
    logic [NL*EW-1:0]  redir_cfg = '0;
    logic [NC*8-1:0]   ctx_phys_id;
    logic [NC*8-1:0]   ctx_logic_id;
    logic              ext_req;
    logic              ext_ack = 1'b0;
    logic [7:0]        ext_vector = 8'h5A;
    logic              msg_valid;
    logic              msg_ready = 1'b1;
    logic [NC-1:0]     msg_target;
    logic [7:0]        msg_vector;
    logic [2:0]        msg_dmode;
    logic              msg_destm, msg_level, msg_trigger;
    logic              err_illegal, err_notarget;

    always #5 clk = ~clk;

    irq_msg_dispatcher i_irq_msg_dispatcher (
        .clk(clk), .rst(rst), .irq_lines(irq_lines), .redir_cfg(redir_cfg),
        .ctx_phys_id(ctx_phys_id), .ctx_logic_id(ctx_logic_id),
        .ext_req(ext_req), .ext_ack(ext_ack), .ext_vector(ext_vector),
        .msg_valid(msg_valid), .msg_ready(msg_ready), .msg_target(msg_target),
        .msg_vector(msg_vector), .msg_dmode(msg_dmode), .msg_destm(msg_destm),
        .msg_level(msg_level), .msg_trigger(msg_trigger),
        .err_illegal(err_illegal), .err_notarget(err_notarget)
    );

    // contexts 0..3: physical 10,11,12,11 ; logical 01,02,04,03
    assign ctx_phys_id  = {8'h11, 8'h12, 8'h11, 8'h10};
    assign ctx_logic_id = {8'h03, 8'h04, 8'h02, 8'h01};

    int errors = 0;
    int checks = 0;
    int mcnt = 0, ecnt = 0, ncnt = 0, req_cycles = 0, req_age = 0, cycles = 0;
    logic [7:0]    mv [0:255];
    logic [NC-1:0] last_tgt;
    logic [7:0]    last_vec;
    logic [2:0]    last_mode;
    logic          last_dm, last_lvl, last_trg;
    int            rot_model = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (!rst) begin
            if (msg_valid && msg_ready) begin
                if (mcnt < 256) mv[mcnt] = msg_vector;
                last_tgt = msg_target; last_vec = msg_vector; last_mode = msg_dmode;
                last_dm = msg_destm; last_lvl = msg_level; last_trg = msg_trigger;
                mcnt++;
            end
            if (err_illegal) ecnt++;
            if (err_notarget) ncnt++;
        end
    end

    // external controller: acknowledges after the request has been seen for three edges
    always @(posedge clk) begin
        #1;
        if (ext_req) begin
            req_cycles++;
            req_age++;
            ext_ack = (req_age >= 3);
        end else begin
            req_age = 0;
            ext_ack = 1'b0;
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 50000) begin
            errors++; checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 50000);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    function automatic logic [EW-1:0] mk(input bit m, input logic [7:0] d, input logic [7:0] v,
                                         input logic [2:0] dm, input bit lg, input bit p, input bit t);
        return {m, d, v, dm, lg, p, t};
    endfunction

    function automatic logic [NC-1:0] log_cand(input logic [7:0] d);
        logic [NC-1:0] r;
        for (int c = 0; c < NC; c++) r[c] = ((ctx_logic_id[c*8 +: 8] & d) != 0);
        return r;
    endfunction

    function automatic logic [NC-1:0] nth(input logic [NC-1:0] cand, input int n);
        logic [NC-1:0] r = '0;
        int k = 0;
        for (int c = 0; c < NC; c++) if (cand[c]) begin
            if (k == n) r[c] = 1'b1;
            k++;
        end
        return r;
    endfunction

    task automatic cyc(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic set(input int line, input logic [EW-1:0] e);
        redir_cfg[line*EW +: EW] = e;
    endtask

    task automatic fire(input int line);
        irq_lines[line] = 1'b1;
        cyc(20);
        irq_lines[line] = 1'b0;
        cyc(2);
    endtask

    initial begin
        int m0, e0, n0;
        logic [NC-1:0] exp_t;
        cyc(3);
        rst = 1'b0;
        #1;
        // R12: reset state
        chk(!msg_valid && !ext_req && !err_illegal && !err_notarget, "R12 reset", msg_valid, 0);

        // R7 and R4: physical 0x11 matches contexts 1 and 3
        set(0, mk(0, 8'h11, 8'h40, 3'b000, 0, 1, 1));
        m0 = mcnt;
        fire(0);
        chk(mcnt == m0 + 1, "R7 count", mcnt - m0, 1);
        chk(last_tgt == 4'b1010, "R7 target", last_tgt, 4'b1010);
        chk(last_vec == 8'h40 && last_mode == 3'b000, "R4 vector/mode", last_vec, 8'h40);
        chk(last_dm == 0 && last_lvl == 1 && last_trg == 1, "R4 flags", {last_dm, last_lvl, last_trg}, 3'b011);

        // R1: a held line gives one message; lower and raise gives another
        m0 = mcnt;
        irq_lines[0] = 1'b1;
        cyc(40);
        chk(mcnt == m0 + 1, "R1 held high", mcnt - m0, 1);
        irq_lines[0] = 1'b0;
        cyc(5);
        chk(mcnt == m0 + 1, "R1 lowering", mcnt - m0, 1);
        fire(0);
        chk(mcnt == m0 + 2, "R1 re-raise", mcnt - m0, 2);

        // R6: broadcast
        set(1, mk(0, 8'hFF, 8'h41, 3'b000, 0, 0, 0));
        fire(1);
        chk(last_tgt == 4'b1111, "R6 broadcast", last_tgt, 4'b1111);

        // R8: logical matching
        set(2, mk(0, 8'h02, 8'h42, 3'b000, 1, 0, 1));
        fire(2);
        chk(last_tgt == log_cand(8'h02) && last_tgt == 4'b1010, "R8 dest 02", last_tgt, 4'b1010);
        chk(last_dm == 1 && last_lvl == 0 && last_trg == 1, "R4 logical flags", {last_dm, last_lvl, last_trg}, 3'b101);
        set(2, mk(0, 8'h05, 8'h42, 3'b000, 1, 0, 1));
        fire(2);
        chk(last_tgt == 4'b1101, "R8 dest 05", last_tgt, 4'b1101);

        // R9: rotation over four, then two candidates
        set(3, mk(0, 8'h07, 8'h43, 3'b001, 1, 0, 0));
        for (int k = 0; k < 6; k++) begin
            fire(3);
            exp_t = nth(log_cand(8'h07), rot_model % 4);
            rot_model++;
            chk(last_tgt == exp_t && last_mode == 3'b001, "R9 rotate four", last_tgt, exp_t);
        end
        set(3, mk(0, 8'h02, 8'h43, 3'b001, 1, 0, 0));
        for (int k = 0; k < 2; k++) begin
            fire(3);
            exp_t = nth(log_cand(8'h02), rot_model % 2);
            rot_model++;
            chk(last_tgt == exp_t, "R9 rotate two", last_tgt, exp_t);
        end

        // R10: lowest priority with physical destination
        set(4, mk(0, 8'h10, 8'h44, 3'b001, 0, 0, 0));
        m0 = mcnt; e0 = ecnt;
        fire(4);
        chk(ecnt == e0 + 1, "R10 error pulse", ecnt - e0, 1);
        chk(mcnt == m0, "R10 nothing sent", mcnt - m0, 0);
        set(3, mk(0, 8'h07, 8'h43, 3'b001, 1, 0, 0));
        fire(3);
        exp_t = nth(log_cand(8'h07), rot_model % 4);
        rot_model++;
        chk(last_tgt == exp_t, "R10 counter untouched", last_tgt, exp_t);

        // R11: empty sets
        set(5, mk(0, 8'h33, 8'h45, 3'b000, 0, 0, 0));
        m0 = mcnt; n0 = ncnt;
        fire(5);
        set(5, mk(0, 8'h08, 8'h45, 3'b001, 1, 0, 0));
        fire(5);
        chk(ncnt == n0 + 2, "R11 no-target pulses", ncnt - n0, 2);
        chk(mcnt == m0, "R11 nothing sent", mcnt - m0, 0);

        // R2: masked rise is dropped and not released by unmasking
        set(6, mk(1, 8'hFF, 8'h46, 3'b000, 0, 0, 0));
        m0 = mcnt;
        irq_lines[6] = 1'b1;
        cyc(20);
        chk(mcnt == m0, "R2 masked", mcnt - m0, 0);
        set(6, mk(0, 8'hFF, 8'h46, 3'b000, 0, 0, 0));
        cyc(20);
        chk(mcnt == m0, "R2 unmask not released", mcnt - m0, 0);
        irq_lines[6] = 1'b0;
        cyc(2);
        fire(6);
        chk(mcnt == m0 + 1 && last_vec == 8'h46, "R2 unmasked rise", mcnt - m0, 1);

        // R3 and R12: simultaneous rises with a stalled sink
        set(0, mk(0, 8'hFF, 8'hA0, 3'b000, 0, 0, 0));
        set(1, mk(0, 8'hFF, 8'hA1, 3'b000, 0, 0, 0));
        set(2, mk(0, 8'hFF, 8'hA2, 3'b000, 0, 0, 0));
        m0 = mcnt;
        msg_ready = 1'b0;
        irq_lines[2:0] = 3'b111;
        cyc(10);
        chk(msg_valid && msg_vector == 8'hA0, "R12 stall hold", msg_vector, 8'hA0);
        cyc(5);
        chk(msg_valid && msg_vector == 8'hA0 && msg_target == 4'b1111, "R12 stall stable", msg_vector, 8'hA0);
        msg_ready = 1'b1;
        cyc(20);
        irq_lines[2:0] = 3'b000;
        cyc(2);
        chk(mcnt == m0 + 3, "R3 count", mcnt - m0, 3);
        chk(mv[m0] == 8'hA0 && mv[m0+1] == 8'hA1 && mv[m0+2] == 8'hA2, "R3 order",
            {mv[m0], mv[m0+1], mv[m0+2]}, 24'hA0A1A2);

        // R5: external vector fetch
        set(7, mk(0, 8'hFF, 8'h99, 3'b111, 0, 1, 0));
        req_cycles = 0;
        fire(7);
        chk(last_vec == 8'h5A, "R5 fetched vector", last_vec, 8'h5A);
        chk(last_mode == 3'b111, "R5 mode copied", last_mode, 3'b111);
        chk(req_cycles == 3, "R5 request held", req_cycles, 3);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule